// File: doc/BRIEF.md
# Page-Mapping Memory Management Unit with Write and Execute Protection

This block sits between an 8-bit CPU with a 16-bit address bus and its memory system. It splits the CPU address space into sixteen 4 KB pages. Each page has a 12-bit mapping entry. The low byte of the entry replaces the page number to form a 20-bit physical address. Two of the four upper bits mark the page as write-protected or as not executable. When the unit is disabled, addresses pass straight through and no protection applies.

Software loads and reads the entries through a 256-byte register window. An external address decoder selects the window with a select strobe. The same window holds a direct enable control and an arming control. Entries and controls can be written only while the unit is disabled. Once the unit is on, only an interrupt vector fetch turns it off again.

A vector-pull strobe from the CPU turns the unit off in the same cycle, so the vector and the handler run unmapped and unprotected. To return to a user task, the handler performs an arming write. The unit then switches on two bus cycles later, so the return-from-interrupt opcode is still fetched unmapped, while the stack pulls that follow use the user map. A write-protected page suppresses the memory write enable. An opcode fetch from a no-execute page raises a one-cycle violation flag and is not blocked.

Top module: `page_mmu`

## Requirements
- R1: After reset the unit is disabled and the maps are zero. While disabled, `phys_addr` = {4'h0, `cpu_addr`}, `mem_we` follows `cpu_we` outside the window and `nx_fault` is 0.
- R2: While enabled, `phys_addr` = {entry[`cpu_addr`[15:12]][7:0], `cpu_addr`[11:0]}.
- R3: A window write at offset 0x00+n loads the low byte of entry n from `cpu_wdata`. A write at offset 0x10+n loads entry bits [11:8] from `cpu_wdata`[3:0]. These writes are ignored while the unit is enabled.
- R4: A window read (`reg_sel`=1, `cpu_we`=0) at offset 0x00+n returns the low byte of entry n. At 0x10+n it returns {4'h0, entry[11:8]}, so WP is data bit 3 and NX is data bit 2. Other offsets with no register return 0.
- R5: Entry bit 11 is WP. While enabled, a write to a page with WP set keeps `mem_we` at 0. A window write never raises `mem_we`.
- R6: Entry bit 10 is NX. While enabled, `nx_fault` is 1 in exactly the cycles where `cpu_sync`=1 and the page has NX set. Address and write enable are unaffected.
- R7: A window write at offset 0x20 while disabled sets the enable to `cpu_wdata`[0] from the next cycle on. A read of 0x20 returns bit 0 = enabled and bit 1 = arm pending.
- R8: A window write at offset 0x21 while disabled arms the unit. The two cycles after the write cycle are still unmapped, and the third cycle is mapped.
- R9: With `vec_pull`=1 the unit behaves as disabled in that same cycle, stays disabled afterwards, and any pending arm is cancelled.
- R10: Asserting reset while an arm is pending cancels it, and the unit stays disabled after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one CPU cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, 1 = write cycle |
| cpu_sync | input | 1 | Opcode fetch cycle marker |
| vec_pull | input | 1 | CPU is reading an interrupt vector |
| reg_sel | input | 1 | Decoder select for the 256-byte register window |
| cpu_rdata | output | 8 | Window readback data, 0 when not reading the window |
| phys_addr | output | 20 | Translated physical address |
| mem_we | output | 1 | Gated memory write enable |
| nx_fault | output | 1 | Opcode fetch from a no-execute page |

## Verification
Translation is tried on several pages with distinct low bytes. Comparing the same address before and after enabling separates the mapped path from the pass-through path. Writes and opcode fetches are issued to pages with WP only, NX only and no flags, in both modes, so that suppression and faults can be told apart from a global gate. The arming write is followed cycle by cycle and then interrupted by a vector pull and by reset, which separates a two-cycle delay from a one- or three-cycle delay and a cancelled arm from one that fires.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int VA_W   = 16;
  localparam int PAGE_W = 4;
  localparam int EXT_W  = 8;
  localparam int HI_W   = 4;
  localparam int WP_POS = 11;
  localparam int NX_POS = 10;
  typedef enum logic [1:0] {ARM_IDLE = 2'd0, ARM_LAST = 2'd1, ARM_FIRST = 2'd2} arm_state_t;
endpackage

// File: rtl/mmu_map_regs.sv
module mmu_map_regs #(
  parameter int PAGE_W = 4,
  parameter int EXT_W  = 8,
  parameter int HI_W   = 4,
  localparam int NPG   = 1 << PAGE_W,
  localparam int ENT_W = EXT_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmu_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] rd_idx,
  input  logic [PAGE_W-1:0] look_idx,
  output logic [ENT_W-1:0]  rd_entry,
  output logic [ENT_W-1:0]  look_entry
);
  logic [EXT_W-1:0] lo_q [NPG];
  logic [HI_W-1:0]  hi_q [NPG];

  for (genvar g = 0; g < NPG; g++) begin : g_ent
    logic sel_lo, sel_hi;
    logic [EXT_W-1:0] lo_d;
    logic [HI_W-1:0]  hi_d;
    always_comb begin
      sel_lo = wr_lo && (wr_idx == PAGE_W'(g));
      sel_hi = wr_hi && (wr_idx == PAGE_W'(g));
      lo_d   = wdata[EXT_W-1:0];
      hi_d   = wdata[HI_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else begin
        if (sel_lo) lo_q[g] <= lo_d;
        if (sel_hi) hi_q[g] <= hi_d;
      end
    end
  end

  always_comb begin
    rd_entry   = {hi_q[rd_idx], lo_q[rd_idx]};
    look_entry = {hi_q[look_idx], lo_q[look_idx]};
  end

  // R3
  locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |-> !mmu_en);
endmodule

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vec_pull,
  input  logic set_wr,
  input  logic set_val,
  input  logic arm_wr,
  output logic en_eff,
  output logic en_q_o,
  output logic armed
);
  logic       en_q, en_d;
  arm_state_t pend_q, pend_d;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    case (pend_q)
      ARM_FIRST: pend_d = ARM_LAST;
      ARM_LAST: begin
        pend_d = ARM_IDLE;
        en_d   = 1'b1;
      end
      default: pend_d = ARM_IDLE;
    endcase
    if (set_wr) en_d = set_val;
    if (arm_wr) pend_d = ARM_FIRST;
    if (vec_pull) begin
      en_d   = 1'b0;
      pend_d = ARM_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= ARM_IDLE;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    en_eff = en_q && !vec_pull;
    en_q_o = en_q;
    armed  = (pend_q != ARM_IDLE);
  end

  // R9
  vpull_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_pull |=> (!en_q && pend_q == ARM_IDLE));
  // R8
  arm_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && !vec_pull) |=> !en_q);
  // R8
  arm_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == ARM_LAST && !vec_pull) |=> en_q);
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate #(
  parameter int VA_W   = 16,
  parameter int PAGE_W = 4,
  parameter int EXT_W  = 8,
  parameter int WP_POS = 11,
  parameter int NX_POS = 10,
  localparam int OFF_W = VA_W - PAGE_W,
  localparam int PA_W  = EXT_W + OFF_W,
  localparam int ENT_W = EXT_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VA_W-1:0]  cpu_addr,
  input  logic             cpu_we,
  input  logic             cpu_sync,
  input  logic             reg_sel,
  input  logic [ENT_W-1:0] entry,
  output logic [PA_W-1:0]  phys_addr,
  output logic             mem_we,
  output logic             nx_fault
);
  logic wp, nx;

  always_comb begin
    wp = en && entry[WP_POS];
    nx = en && entry[NX_POS];
    if (en) phys_addr = {entry[EXT_W-1:0], cpu_addr[OFF_W-1:0]};
    else    phys_addr = PA_W'(cpu_addr);
    mem_we   = cpu_we && !reg_sel && !wp;
    nx_fault = cpu_sync && nx;
  end

  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (phys_addr == PA_W'(cpu_addr) && !nx_fault));
  // R5
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && entry[WP_POS]) |-> !mem_we);
  // R6
  nx_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nx_fault |-> (cpu_sync && en));
endmodule

// File: rtl/page_mmu.sv
module page_mmu
  import mmu_pkg::*;
#(
  parameter int VA_W_P   = VA_W,
  parameter int PAGE_W_P = PAGE_W,
  parameter int EXT_W_P  = EXT_W,
  localparam int OFF_W   = VA_W_P - PAGE_W_P,
  localparam int PA_W    = EXT_W_P + OFF_W,
  localparam int ENT_W   = EXT_W_P + HI_W,
  localparam logic [7:0] CTRL_OFS = 8'(2 << PAGE_W_P),
  localparam logic [7:0] ARM_OFS  = 8'((2 << PAGE_W_P) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W_P-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_sync,
  input  logic              vec_pull,
  input  logic              reg_sel,
  output logic [7:0]        cpu_rdata,
  output logic [PA_W-1:0]   phys_addr,
  output logic              mem_we,
  output logic              nx_fault
);
  logic [1:0]          rst_sync_q;
  logic                rst_core_n;
  logic [7:0]          ofs;
  logic [PAGE_W_P-1:0] ofs_idx;
  logic [7-PAGE_W_P:0] ofs_grp;
  logic                en_eff, en_q, armed;
  logic                kwr, wr_lo, wr_hi, set_wr, arm_wr;
  logic [ENT_W-1:0]    rd_entry, look_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    ofs     = cpu_addr[7:0];
    ofs_idx = ofs[PAGE_W_P-1:0];
    ofs_grp = ofs[7:PAGE_W_P];
    kwr     = reg_sel && cpu_we && !en_eff;
    wr_lo   = kwr && (ofs_grp == '0);
    wr_hi   = kwr && (ofs_grp == (8-PAGE_W_P)'(1));
    set_wr  = kwr && (ofs == CTRL_OFS);
    arm_wr  = kwr && (ofs == ARM_OFS);
  end

  mmu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .vec_pull(vec_pull),
    .set_wr(set_wr), .set_val(cpu_wdata[0]), .arm_wr(arm_wr),
    .en_eff(en_eff), .en_q_o(en_q), .armed(armed)
  );

  mmu_map_regs #(.PAGE_W(PAGE_W_P), .EXT_W(EXT_W_P), .HI_W(HI_W)) u_maps (
    .clk(clk), .rst_n(rst_core_n), .mmu_en(en_eff),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_idx(ofs_idx), .wdata(cpu_wdata),
    .rd_idx(ofs_idx), .look_idx(cpu_addr[VA_W_P-1:OFF_W]),
    .rd_entry(rd_entry), .look_entry(look_entry)
  );

  mmu_xlate #(.VA_W(VA_W_P), .PAGE_W(PAGE_W_P), .EXT_W(EXT_W_P),
              .WP_POS(WP_POS), .NX_POS(NX_POS)) u_xlate (
    .clk(clk), .rst_n(rst_core_n), .en(en_eff), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_sync(cpu_sync), .reg_sel(reg_sel),
    .entry(look_entry), .phys_addr(phys_addr), .mem_we(mem_we),
    .nx_fault(nx_fault)
  );

  always_comb begin
    cpu_rdata = 8'h00;
    if (reg_sel && !cpu_we) begin
      if (ofs_grp == '0)                            cpu_rdata = 8'(rd_entry[EXT_W_P-1:0]);
      else if (ofs_grp == (8-PAGE_W_P)'(1))        cpu_rdata = 8'(rd_entry[ENT_W-1:EXT_W_P]);
      else if (ofs == CTRL_OFS)                    cpu_rdata = {6'b0, armed, en_q};
    end
  end

  // R5
  win_no_we_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    reg_sel |-> !mem_we);
  // R7
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (set_wr && !vec_pull) |=> (en_q == $past(cpu_wdata[0])));
endmodule

// File: tb/test_page_mmu.sv
module test_page_mmu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we, cpu_sync, vec_pull, reg_sel;
  logic [7:0]  cpu_rdata;
  logic [19:0] phys_addr;
  logic        mem_we, nx_fault;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  page_mmu i_page_mmu (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_sync(cpu_sync), .vec_pull(vec_pull), .reg_sel(reg_sel),
    .cpu_rdata(cpu_rdata), .phys_addr(phys_addr), .mem_we(mem_we), .nx_fault(nx_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input logic [15:0] a);
    cpu_addr = a; cpu_wdata = 8'h00; cpu_we = 1'b0;
    cpu_sync = 1'b0; vec_pull = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [7:0] d);
    idle({8'hE0, ofs}); reg_sel = 1'b1; cpu_we = 1'b1; cpu_wdata = d;
    @(posedge clk); @(negedge clk); idle(16'h0000);
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [7:0] d);
    idle({8'hE0, ofs}); reg_sel = 1'b1; #1 d = cpu_rdata;
    @(posedge clk); @(negedge clk); idle(16'h0000);
  endtask

  task automatic vpull();
    idle(16'hFFFE); vec_pull = 1'b1;
    @(posedge clk); @(negedge clk); idle(16'h0000);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    idle(16'hABCD); cpu_we = 1'b1; cpu_sync = 1'b1; #1;
    chk("R1 reset passthru addr", phys_addr, 20'h0ABCD);
    chk("R1 reset mem_we", mem_we, 1);
    chk("R1 reset nx_fault", nx_fault, 0);
    @(negedge clk);
    rd(8'h20, d); chk("R1 R7 reset ctrl", d, 8'h00);
    rd(8'h07, d); chk("R1 reset map zero", d, 8'h00);
  endtask

  task automatic t_load();
    logic [7:0] d;
    wr(8'h03, 8'h5A); wr(8'h04, 8'h12); wr(8'h14, 8'hF8);
    wr(8'h05, 8'hC3); wr(8'h15, 8'h04); wr(8'h0F, 8'hFF);
    rd(8'h03, d); chk("R3 R4 low byte p3", d, 8'h5A);
    rd(8'h14, d); chk("R3 R4 high nibble WP p4", d, 8'h08);
    rd(8'h15, d); chk("R4 high nibble NX p5", d, 8'h04);
    rd(8'h0F, d); chk("R4 low byte p15", d, 8'hFF);
    rd(8'h40, d); chk("R4 unused offset", d, 8'h00);
    idle(16'h4010); cpu_we = 1'b1; #1;
    chk("R1 WP ignored while disabled", mem_we, 1);
    @(negedge clk); idle(16'h0000);
  endtask

  task automatic t_direct();
    logic [7:0] d;
    wr(8'h20, 8'h01);
    idle(16'h3123); #1;
    chk("R7 R2 mapped after direct enable", phys_addr, 20'h5A123);
    cpu_addr = 16'hF00E; #1;
    chk("R2 page15", phys_addr, 20'hFF00E);
    cpu_addr = 16'h0777; #1;
    chk("R2 page0 zero entry", phys_addr, 20'h00777);
    @(negedge clk);
    rd(8'h20, d); chk("R7 ctrl readback enabled", d, 8'h01);
  endtask

  task automatic t_protect();
    idle(16'h4010); cpu_we = 1'b1; #1;
    chk("R5 WP blocks write", mem_we, 0);
    chk("R2 WP page addr", phys_addr, 20'h12010);
    cpu_addr = 16'h3001; #1;
    chk("R5 unprotected page write", mem_we, 1);
    cpu_addr = 16'hE003; reg_sel = 1'b1; #1;
    chk("R5 window write no mem_we", mem_we, 0);
    @(negedge clk);
    idle(16'h5100); cpu_sync = 1'b1; #1;
    chk("R6 NX fetch fault", nx_fault, 1);
    chk("R6 NX fetch addr", phys_addr, 20'hC3100);
    cpu_sync = 1'b0; #1;
    chk("R6 NX data read no fault", nx_fault, 0);
    cpu_addr = 16'h3100; cpu_sync = 1'b1; #1;
    chk("R6 non-NX fetch no fault", nx_fault, 0);
    @(negedge clk); idle(16'h0000);
  endtask

  task automatic t_locked_vpull();
    logic [7:0] d;
    wr(8'h03, 8'h77);
    wr(8'h20, 8'h00);
    idle(16'h3123); vec_pull = 1'b1; #1;
    chk("R9 immediate passthru on vector pull", phys_addr, 20'h03123);
    @(negedge clk); vec_pull = 1'b0; #1;
    chk("R9 stays disabled", phys_addr, 20'h03123);
    @(negedge clk); idle(16'h0000);
    rd(8'h03, d); chk("R3 write while enabled ignored", d, 8'h5A);
  endtask

  task automatic t_arm();
    wr(8'h21, 8'h00);
    cpu_addr = 16'h3123; #1;
    chk("R8 cycle1 after arm unmapped", phys_addr, 20'h03123);
    @(negedge clk); cpu_addr = 16'h3123; #1;
    chk("R8 cycle2 after arm unmapped", phys_addr, 20'h03123);
    @(negedge clk); cpu_addr = 16'h3123; #1;
    chk("R8 cycle3 after arm mapped", phys_addr, 20'h5A123);
    @(negedge clk);
    vpull();
  endtask

  task automatic t_arm_cancel_vec();
    logic [7:0] d;
    wr(8'h21, 8'h00);
    rd(8'h20, d); chk("R7 arm pending readback", d, 8'h02);
    vpull();
    cpu_addr = 16'h3123;
    repeat (3) @(negedge clk);
    #1 chk("R9 vector pull cancels arm", phys_addr, 20'h03123);
    @(negedge clk);
  endtask

  task automatic t_arm_cancel_reset();
    logic [7:0] d;
    wr(8'h21, 8'h00);
    do_reset();
    wr(8'h03, 8'h5A);
    idle(16'h3123);
    repeat (3) @(negedge clk);
    #1 chk("R10 reset cancels arm", phys_addr, 20'h03123);
    @(negedge clk);
    rd(8'h20, d); chk("R10 ctrl after reset", d, 8'h00);
  endtask

  initial begin
    idle(16'h0000);
    do_reset();
    t_reset();
    t_load();
    t_direct();
    t_protect();
    t_locked_vpull();
    t_arm();
    t_arm_cancel_vec();
    t_arm_cancel_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule